// File: doc/BRIEF.md
# Character-Driven JTAG Pin Bridge

This block turns a stream of ASCII command bytes into levels on four JTAG pins: clock, mode select, data in, and an active-low test reset. Each accepted byte is one command. A digit from 0 to 7 sets the clock, mode and data pins together from its low three bits. Four lower-case letters drive the reset pin. An upper-case read command samples the target's data-out pin and sends back one ASCII digit on an output byte stream. Any other byte is consumed and does nothing.

Both byte interfaces use valid/ready. A byte moves on the input when `in_valid` and `in_ready` are both high at a rising edge. A byte moves on the output when `out_valid` and `out_ready` are both high at a rising edge. The block holds one pending response byte. While that byte waits and the consumer is not ready, `in_ready` is low, so commands stall and no response can be lost. When the pending byte leaves in the same cycle that a new read is accepted, the new response takes its place with no idle cycle. Commands take effect in arrival order. The pins are registered and keep their values between commands.

Top module: `jtag_char_bridge`

## Requirements
- R1: During and after reset the outputs are tck=0, tms=1, tdi=0, trst_n=1, out_valid=0 and in_ready=1.
- R2: An accepted byte from 0x30 to 0x37 sets tck to bit 2, tms to bit 1 and tdi to bit 0 of the byte. The new levels appear after the accepting edge. trst_n is unchanged.
- R3: An accepted 0x72 or 0x73 drives trst_n to 1 after the accepting edge. tck, tms and tdi are unchanged.
- R4: An accepted 0x74 or 0x75 drives trst_n to 0 after the accepting edge. tck, tms and tdi are unchanged.
- R5: An accepted 0x52 samples tdo in the accepting cycle. After that edge, out_valid is 1 and out_data is 0x30 plus the sampled bit (0x30 or 0x31).
- R6: Any other accepted byte, including 0x2F and 0x38, leaves all four pins unchanged and produces no response byte.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays stable.
- R8: in_ready is 0 exactly when out_valid is 1 and out_ready is 0. While in_ready is 0, a presented byte has no effect.
- R9: If a response leaves and a new 0x52 is accepted in the same cycle, out_valid stays 1 and out_data carries the new sample.
- R10: In a cycle with no accepted byte, the four pins keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A command byte is offered |
| in_ready | output | 1 | The bridge can take a command byte |
| in_data | input | 8 | ASCII command byte |
| out_valid | output | 1 | A response byte is pending |
| out_ready | input | 1 | The consumer takes the response byte |
| out_data | output | 8 | ASCII response, 0x30 or 0x31 |
| tdo | input | 1 | Data-out level from the target |
| tck | output | 1 | JTAG clock pin |
| tms | output | 1 | JTAG mode-select pin |
| tdi | output | 1 | JTAG data-in pin |
| trst_n | output | 1 | JTAG test reset, active low |

## Verification
Two events can fall in the same cycle: the pending response byte leaving, and a new read command being accepted. To provoke this, the bench holds a response with out_ready low while tdo is driven to 1. It then changes tdo to 0 and raises out_ready in the same cycle that it presents a new read. The result counts as correct only if out_valid stays high across that edge and out_data changes from 0x31 to 0x30. When the bench then stops issuing reads, out_valid must drop after one more edge.

// File: rtl/jcb_pkg.sv
package jcb_pkg;
  localparam int BYTE_W = 8;
  localparam int NPINS  = 3; // tck, tms, tdi

  localparam logic [BYTE_W-1:0] ASCII_ZERO   = 8'h30;
  localparam logic [BYTE_W-1:0] CH_REL_A     = 8'h72;
  localparam logic [BYTE_W-1:0] CH_REL_B     = 8'h73;
  localparam logic [BYTE_W-1:0] CH_HOLD_A    = 8'h74;
  localparam logic [BYTE_W-1:0] CH_HOLD_B    = 8'h75;
  localparam logic [BYTE_W-1:0] CH_SAMPLE    = 8'h52;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PINS,
    OP_RST_ON,
    OP_RST_OFF,
    OP_READ
  } op_e;

  function automatic op_e classify(input logic [BYTE_W-1:0] c);
    op_e r;
    if (c[BYTE_W-1:NPINS] == ASCII_ZERO[BYTE_W-1:NPINS]) r = OP_PINS;
    else if (c == CH_REL_A || c == CH_REL_B) r = OP_RST_OFF;
    else if (c == CH_HOLD_A || c == CH_HOLD_B) r = OP_RST_ON;
    else if (c == CH_SAMPLE) r = OP_READ;
    else r = OP_NONE;
    return r;
  endfunction
endpackage

// File: rtl/jcb_decode.sv
module jcb_decode
  import jcb_pkg::*;
#(
  parameter int W = BYTE_W,
  parameter int P = NPINS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic [W-1:0] cmd,
  output logic         pins_stb,
  output logic [P-1:0] pins_val,
  output logic         rst_on_stb,
  output logic         rst_off_stb,
  output logic         read_stb
);
  op_e op;

  always_comb begin
    op          = classify(cmd);
    pins_stb    = accept && (op == OP_PINS);
    rst_on_stb  = accept && (op == OP_RST_ON);
    rst_off_stb = accept && (op == OP_RST_OFF);
    read_stb    = accept && (op == OP_READ);
    pins_val    = cmd[P-1:0];
  end

  // R6: at most one action per accepted byte; none without an accept.
  assert_one_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pins_stb, rst_on_stb, rst_off_stb, read_stb}));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> !(pins_stb || rst_on_stb || rst_off_stb || read_stb));
endmodule

// File: rtl/jcb_pins.sv
module jcb_pins
  import jcb_pkg::*;
#(
  parameter int           P           = NPINS,
  parameter logic [P-1:0] RESET_PINS  = 3'b010,
  parameter logic         RESET_TRSTN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pins_stb,
  input  logic [P-1:0] pins_val,
  input  logic         rst_on_stb,
  input  logic         rst_off_stb,
  output logic [P-1:0] pins_q,
  output logic         trst_n_q
);
  for (genvar i = 0; i < P; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pins_q[i] <= RESET_PINS[i];
      else if (pins_stb) pins_q[i] <= pins_val[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           trst_n_q <= RESET_TRSTN;
    else if (rst_on_stb)  trst_n_q <= 1'b0;
    else if (rst_off_stb) trst_n_q <= 1'b1;
  end

  assert_pins_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pins_stb |=> (pins_q == $past(pins_val)) && $stable(trst_n_q));
  assert_trst_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_on_stb |=> !trst_n_q && $stable(pins_q));
  assert_trst_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_off_stb |=> trst_n_q && $stable(pins_q));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pins_stb || rst_on_stb || rst_off_stb) |=> $stable({pins_q, trst_n_q}));
endmodule

// File: rtl/jcb_resp.sv
module jcb_resp
  import jcb_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         sample,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         space
);
  logic pop;

  assign pop   = out_valid && out_ready;
  assign space = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= ASCII_ZERO;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ASCII_ZERO | {{(W-1){1'b0}}, sample};
    end else if (pop) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));
  assert_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid && (out_data[W-1:1] == ASCII_ZERO[W-1:1]) && (out_data[0] == $past(sample)));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> space);
  assert_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && pop) |=> out_valid);
endmodule

// File: rtl/jtag_char_bridge.sv
module jtag_char_bridge
  import jcb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  input  logic       tdo,
  output logic       tck,
  output logic       tms,
  output logic       tdi,
  output logic       trst_n
);
  logic             accept;
  logic             pins_stb, rst_on_stb, rst_off_stb, read_stb;
  logic [NPINS-1:0] pins_val, pins_q;

  assign accept = in_valid && in_ready;

  jcb_decode #(.W(BYTE_W), .P(NPINS)) u_dec (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmd(in_data),
    .pins_stb(pins_stb), .pins_val(pins_val),
    .rst_on_stb(rst_on_stb), .rst_off_stb(rst_off_stb), .read_stb(read_stb)
  );

  jcb_pins #(.P(NPINS), .RESET_PINS(3'b010), .RESET_TRSTN(1'b1)) u_pins (
    .clk(clk), .rst_n(rst_n), .pins_stb(pins_stb), .pins_val(pins_val),
    .rst_on_stb(rst_on_stb), .rst_off_stb(rst_off_stb),
    .pins_q(pins_q), .trst_n_q(trst_n)
  );

  jcb_resp #(.W(BYTE_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .load(read_stb), .sample(tdo),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .space(in_ready)
  );

  assign tck = pins_q[2];
  assign tms = pins_q[1];
  assign tdi = pins_q[0];

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable({tck, tms, tdi, trst_n}));
endmodule

// File: tb/jtag_char_bridge_test.sv
module jtag_char_bridge_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_ready = 1'b1;
  logic       loop_en = 1'b1;
  logic       tdo_drv = 1'b0;
  logic       in_ready, out_valid, tck, tms, tdi, trst_n, tdo;
  logic [7:0] out_data;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;
  assign tdo = loop_en ? tdi : tdo_drv;

  jtag_char_bridge uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .tdo(tdo), .tck(tck), .tms(tms), .tdi(tdi),
    .trst_n(trst_n)
  );

  // entry: {command, expected {tck,tms,tdi,trst_n}, response expected, response byte}
  localparam int NV = 18;
  localparam logic [20:0] VEC [NV] = '{
    {8'h35, 4'b1011, 1'b0, 8'h00},  // R2 '5'
    {8'h52, 4'b1011, 1'b1, 8'h31},  // R5 read tdi=1
    {8'h32, 4'b0101, 1'b0, 8'h00},  // R2 '2'
    {8'h52, 4'b0101, 1'b1, 8'h30},  // R5 read tdi=0
    {8'h74, 4'b0100, 1'b0, 8'h00},  // R4 't'
    {8'h78, 4'b0100, 1'b0, 8'h00},  // R6 'x'
    {8'h37, 4'b1110, 1'b0, 8'h00},  // R2 '7'
    {8'h52, 4'b1110, 1'b1, 8'h31},  // R5
    {8'h72, 4'b1111, 1'b0, 8'h00},  // R3 'r'
    {8'h75, 4'b1110, 1'b0, 8'h00},  // R4 'u'
    {8'h73, 4'b1111, 1'b0, 8'h00},  // R3 's'
    {8'h30, 4'b0001, 1'b0, 8'h00},  // R2 '0'
    {8'h51, 4'b0001, 1'b0, 8'h00},  // R6 'Q'
    {8'h52, 4'b0001, 1'b1, 8'h30},  // R5
    {8'h2F, 4'b0001, 1'b0, 8'h00},  // R6 below '0'
    {8'h38, 4'b0001, 1'b0, 8'h00},  // R6 above '7'
    {8'h36, 4'b1101, 1'b0, 8'h00},  // R2 '6'
    {8'h52, 4'b1101, 1'b1, 8'h30}   // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = c;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic reset_check(input string tag);
    chk({tag, " R1 pins"}, {28'd0, tck, tms, tdi, trst_n}, 32'b0101);
    chk({tag, " R1 out_valid"}, {31'd0, out_valid}, 32'd0);
    chk({tag, " R1 in_ready"}, {31'd0, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_check("reset asserted");
    rst_n = 1'b1;
    @(negedge clk);
    reset_check("after reset");

    // vector walk, tdo looped back from tdi, consumer always ready
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][20:13]);
      chk($sformatf("R2/R3/R4/R6 vec %0d pins", i), {28'd0, tck, tms, tdi, trst_n}, {28'd0, VEC[i][12:9]});
      chk($sformatf("R5/R6 vec %0d valid", i), {31'd0, out_valid}, {31'd0, VEC[i][8]});
      if (VEC[i][8]) chk($sformatf("R5 vec %0d byte", i), {24'd0, out_data}, {24'd0, VEC[i][7:0]});
    end

    // R10: idle cycles keep pins
    repeat (4) @(negedge clk);
    chk("R10 idle hold", {28'd0, tck, tms, tdi, trst_n}, 32'b1101);

    // R7/R8: back-pressure
    send(8'h31);                       // pins 0,0,1
    out_ready = 1'b0;
    send(8'h52);
    chk("R5 pending valid", {31'd0, out_valid}, 32'd1);
    chk("R5 pending byte", {24'd0, out_data}, 32'h31);
    chk("R8 in_ready low", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h34;
    repeat (3) @(negedge clk);
    chk("R8 stalled pins", {28'd0, tck, tms, tdi, trst_n}, 32'b0011);
    chk("R7 held valid", {31'd0, out_valid}, 32'd1);
    chk("R7 held byte", {24'd0, out_data}, 32'h31);
    in_valid = 1'b0;

    // R9: pop and new read in one cycle
    loop_en = 1'b0;
    tdo_drv = 1'b0;
    @(negedge clk);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    in_data   = 8'h52;
    #1;
    chk("R8 ready with consumer", {31'd0, in_ready}, 32'd1);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk("R9 valid kept", {31'd0, out_valid}, 32'd1);
    chk("R9 new byte", {24'd0, out_data}, 32'h30);
    @(posedge clk);
    #1;
    chk("R9 drained", {31'd0, out_valid}, 32'd0);

    // R1: mid-stream reset
    send(8'h74);
    send(8'h36);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    reset_check("mid reset");
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule